// File: doc/BRIEF.md
# Serial Memory Write-Protect Gate

This block sits between the protocol engine of a two-wire serial memory and its 8192-byte storage array. It decides whether a write request may reach the array or the control register. It compares the device-address bits received from the bus with the strapped select pins, so that up to four devices can share one bus. It also holds the current byte address for the array and advances it through a page during a multi-byte write. Each byte is checked against a protected range that ends at the top of the array.

The protected range comes from a stored 3-bit field. The field selects no protection, the top quarter, the top half, the entire array, or a small top block of 64, 128, 256 or 512 bytes. Control-register writes are refused when the write-protect pin is high and the stored protect-enable bit is set. A blocked write produces no enable pulse, so the array or register keeps its contents. Reads never pass through this gate.

Top module: `wp_gate`

## Requirements
- R1: While reset is asserted, and after it is released, the array address output `arrAddr` is 0.
- R2: `addrMatch` is high exactly when `busSel` equals `selPins`. All four select values are usable.
- R3: While `addrMatch` is low, `arrayWrEn` and `ctrlWrEn` stay low, and `arrAddr` does not change at the next clock edge. This holds even when a load or a write request is present.
- R4: `arrayWrEn` follows `arrayWrReq` in the same cycle when the device is matched and `arrAddr` lies outside the protected range. Every protected range ends at address 8191. The encodings of `protField` are: 000 none; 001 addresses 6144 and up; 010 addresses 4096 and up; 011 every address; 100 addresses 8128 and up; 101 addresses 8064 and up; 110 addresses 7936 and up; 111 addresses 7680 and up.
- R5: `protField` has no effect on `addrMatch` or `ctrlWrEn`.
- R6: When matched, `loadAddr` copies `byteAddr` into `arrAddr` at the next clock edge. A load takes priority over a simultaneous address step.
- R7: When matched, each array write request without a load advances `arrAddr` bits [5:0] by one at the next edge. The count wraps from 63 to 0, and bits [12:6] are held. This happens whether the byte was protected or not, and each byte is checked against the range on its own.
- R8: `pageEnd` is high exactly when `arrAddr` bits [5:0] are all ones.
- R9: `ctrlWrEn` is high when `ctrlWrReq` is high and the device is matched, unless both `wpPin` and `wpEnBit` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selPins | input | 2 | Strapped device-select pins |
| busSel | input | 2 | Device-address bits received from the bus |
| byteAddr | input | 13 | Byte address received from the bus |
| loadAddr | input | 1 | Load `byteAddr` into the address register |
| arrayWrReq | input | 1 | Request to write one byte to the array |
| ctrlWrReq | input | 1 | Request to write the control register |
| wpPin | input | 1 | Write-protect pin level |
| wpEnBit | input | 1 | Stored protect-enable bit |
| protField | input | 3 | Stored protection-range field |
| addrMatch | output | 1 | Bus device address selects this device |
| arrayWrEn | output | 1 | Array write allowed by the gate |
| ctrlWrEn | output | 1 | Control-register write allowed by the gate |
| arrAddr | output | 13 | Byte address that the array write uses |
| pageEnd | output | 1 | Address is the last byte of its page |

## Verification
The bench builds the block with its default parameters: a 13-bit address, 64-byte pages, a 64-byte base block and 2 select bits. At this size every one of the eight protection encodings can be paired with every one of the 8192 addresses, so each range boundary is exercised from both sides. All sixteen select-pin and bus-bit pairs are crossed with every protection encoding. All four write-protect combinations are driven as well. Page walks are started near page ends to check the wrap at 63, including the wrap at the top of the array.

// File: rtl/wp_gate_pkg.sv
`timescale 1ns/1ps
package wp_gate_pkg;

  // Encodings of the stored protection-range field
  typedef enum logic [2:0] {
    PROT_NONE    = 3'b000,
    PROT_QUARTER = 3'b001,
    PROT_HALF    = 3'b010,
    PROT_ALL     = 3'b011,
    PROT_BLK1    = 3'b100,
    PROT_BLK2    = 3'b101,
    PROT_BLK4    = 3'b110,
    PROT_BLK8    = 3'b111
  } protSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadAddr;   // capture bus byte address
    logic stepAddr;   // advance within page
    logic arrayPass;  // matched array write request
  } gateStrobe_t;

endpackage

// File: rtl/wp_gate_ctrl.sv
`timescale 1ns/1ps
module wp_gate_ctrl
  import wp_gate_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] selPins,
  input  logic [SEL_W-1:0] busSel,
  input  logic             loadAddr,
  input  logic             arrayWrReq,
  input  logic             ctrlWrReq,
  input  logic             wpPin,
  input  logic             wpEnBit,
  output logic             addrMatch,
  output logic             ctrlWrEn,
  output gateStrobe_t      strobe
);

  logic selHit;
  logic regLocked;

  // Per-bit comparison of strapped pins and received bits
  logic [SEL_W-1:0] bitEq;
  for (genvar i = 0; i < SEL_W; i++) begin : g_selCmp
    assign bitEq[i] = ~(selPins[i] ^ busSel[i]);
  end

  always_comb begin
    selHit    = &bitEq;
    regLocked = wpPin & wpEnBit;
  end

  always_comb begin
    addrMatch       = selHit;
    ctrlWrEn        = ctrlWrReq & selHit & ~regLocked;
    strobe.loadAddr = loadAddr & selHit;
    strobe.stepAddr = arrayWrReq & selHit & ~loadAddr;
    strobe.arrayPass = arrayWrReq & selHit;
  end

endmodule

// File: rtl/wp_gate_dp.sv
`timescale 1ns/1ps
module wp_gate_dp
  import wp_gate_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int PAGE_W    = 6,
  parameter int BLK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [2:0]        protField,
  output logic [ADDR_W-1:0] arrAddr,
  output logic              arrayWrEn,
  output logic              pageEnd
);

  localparam int CW = ADDR_W + 1;
  localparam logic [CW-1:0] DEPTH   = CW'(1) << ADDR_W;
  localparam logic [CW-1:0] QUARTER = DEPTH >> 2;
  localparam logic [CW-1:0] HALF    = DEPTH >> 1;
  localparam logic [CW-1:0] BLK     = CW'(BLK_BYTES);

  logic [PAGE_W-1:0] offsetQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                offsetQ <= '0;
    else if (strobe.loadAddr) offsetQ <= byteAddr[PAGE_W-1:0];
    else if (strobe.stepAddr) offsetQ <= offsetQ + 1'b1;
  end

  generate
    if (PAGE_W < ADDR_W) begin : g_split
      logic [ADDR_W-PAGE_W-1:0] pageQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                pageQ <= '0;
        else if (strobe.loadAddr) pageQ <= byteAddr[ADDR_W-1:PAGE_W];
      end
      assign arrAddr = {pageQ, offsetQ};
    end else begin : g_single
      assign arrAddr = offsetQ;
    end
  endgenerate

  // Lower bound of the protected range; range always ends at the top
  logic [CW-1:0] protLo;
  always_comb begin
    unique case (protSel_e'(protField))
      PROT_NONE:    protLo = DEPTH;
      PROT_QUARTER: protLo = DEPTH - QUARTER;
      PROT_HALF:    protLo = DEPTH - HALF;
      PROT_ALL:     protLo = '0;
      default:      protLo = DEPTH - (BLK << protField[1:0]);
    endcase
  end

  logic inProt;
  always_comb begin
    inProt    = {1'b0, arrAddr} >= protLo;
    arrayWrEn = strobe.arrayPass & ~inProt;
    pageEnd   = &offsetQ;
  end

endmodule

// File: rtl/wp_gate.sv
`timescale 1ns/1ps
module wp_gate
  import wp_gate_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int PAGE_W    = 6,
  parameter int BLK_BYTES = 64,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  selPins,
  input  logic [SEL_W-1:0]  busSel,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic              loadAddr,
  input  logic              arrayWrReq,
  input  logic              ctrlWrReq,
  input  logic              wpPin,
  input  logic              wpEnBit,
  input  logic [2:0]        protField,
  output logic              addrMatch,
  output logic              arrayWrEn,
  output logic              ctrlWrEn,
  output logic [ADDR_W-1:0] arrAddr,
  output logic              pageEnd
);

  gateStrobe_t strobe;

  wp_gate_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .selPins    (selPins),
    .busSel     (busSel),
    .loadAddr   (loadAddr),
    .arrayWrReq (arrayWrReq),
    .ctrlWrReq  (ctrlWrReq),
    .wpPin      (wpPin),
    .wpEnBit    (wpEnBit),
    .addrMatch  (addrMatch),
    .ctrlWrEn   (ctrlWrEn),
    .strobe     (strobe)
  );

  wp_gate_dp #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W),
    .BLK_BYTES (BLK_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .byteAddr  (byteAddr),
    .protField (protField),
    .arrAddr   (arrAddr),
    .arrayWrEn (arrayWrEn),
    .pageEnd   (pageEnd)
  );

endmodule

// File: rtl/wp_gate_chk.sv
`timescale 1ns/1ps
module wp_gate_chk #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrMatch,
  input logic              loadAddr,
  input logic              arrayWrReq,
  input logic              ctrlWrReq,
  input logic              wpPin,
  input logic              wpEnBit,
  input logic [2:0]        protField,
  input logic [ADDR_W-1:0] byteAddr,
  input logic [ADDR_W-1:0] arrAddr,
  input logic              arrayWrEn,
  input logic              ctrlWrEn
);

  a_r3_no_pass_unmatched: assert property (@(posedge clk) disable iff (!rstN)
    !addrMatch |-> (!arrayWrEn && !ctrlWrEn));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !addrMatch |=> $stable(arrAddr));

  a_r6_load: assert property (@(posedge clk) disable iff (!rstN)
    (addrMatch && loadAddr) |=> (arrAddr == $past(byteAddr)));

  a_r7_page_step: assert property (@(posedge clk) disable iff (!rstN)
    (addrMatch && arrayWrReq && !loadAddr) |=>
      ((arrAddr[ADDR_W-1:PAGE_W] == $past(arrAddr[ADDR_W-1:PAGE_W])) &&
       (arrAddr[PAGE_W-1:0] == PAGE_W'($past(arrAddr[PAGE_W-1:0]) + 1'b1))));

  a_r4_all_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (protField == 3'b011) |-> !arrayWrEn);

  a_r4_none_open: assert property (@(posedge clk) disable iff (!rstN)
    (protField == 3'b000 && arrayWrReq && addrMatch) |-> arrayWrEn);

  a_r9_reg_locked: assert property (@(posedge clk) disable iff (!rstN)
    (wpPin && wpEnBit) |-> !ctrlWrEn);

  a_r9_reg_open: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrReq && addrMatch && !(wpPin && wpEnBit)) |-> ctrlWrEn);

endmodule

bind wp_gate wp_gate_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addrMatch  (addrMatch),
  .loadAddr   (loadAddr),
  .arrayWrReq (arrayWrReq),
  .ctrlWrReq  (ctrlWrReq),
  .wpPin      (wpPin),
  .wpEnBit    (wpEnBit),
  .protField  (protField),
  .byteAddr   (byteAddr),
  .arrAddr    (arrAddr),
  .arrayWrEn  (arrayWrEn),
  .ctrlWrEn   (ctrlWrEn)
);

// File: tb/wp_gate_test.sv
`timescale 1ns/1ps
module wp_gate_test;

  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    selPins = 2'b10;
  logic [1:0]    busSel = 2'b10;
  logic [AW-1:0] byteAddr = '0;
  logic          loadAddr = 1'b0;
  logic          arrayWrReq = 1'b0;
  logic          ctrlWrReq = 1'b0;
  logic          wpPin = 1'b0;
  logic          wpEnBit = 1'b0;
  logic [2:0]    protField = 3'b000;
  logic          addrMatch, arrayWrEn, ctrlWrEn, pageEnd;
  logic [AW-1:0] arrAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wp_gate uut (
    .clk(clk), .rstN(rstN), .selPins(selPins), .busSel(busSel),
    .byteAddr(byteAddr), .loadAddr(loadAddr), .arrayWrReq(arrayWrReq),
    .ctrlWrReq(ctrlWrReq), .wpPin(wpPin), .wpEnBit(wpEnBit),
    .protField(protField), .addrMatch(addrMatch), .arrayWrEn(arrayWrEn),
    .ctrlWrEn(ctrlWrEn), .arrAddr(arrAddr), .pageEnd(pageEnd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Lower bound of protected range per R4, computed arithmetically
  function automatic int protLo(input int f);
    case (f)
      0: return 8192;
      1: return 8192 - 8192 / 4;
      2: return 8192 / 2;
      3: return 0;
      default: return 8192 - (64 << (f - 4));
    endcase
  endfunction

  task automatic loadTo(input int a);
    @(negedge clk);
    loadAddr = 1'b1; arrayWrReq = 1'b0; byteAddr = AW'(a);
    @(negedge clk);
    loadAddr = 1'b0;
  endtask

  // Page walk: n matched write requests from a start address
  task automatic walk(input int f, input int start, input int n);
    int a;
    protField = 3'(f);
    loadTo(start);
    a = start;
    for (int k = 0; k < n; k++) begin
      arrayWrReq = 1'b1;
      #1;
      chk("R7 walk addr", int'(arrAddr), a);
      chk("R4 walk enable", int'(arrayWrEn), (a >= protLo(f)) ? 0 : 1);
      chk("R8 walk pageEnd", int'(pageEnd), ((a % 64) == 63) ? 1 : 0);
      @(negedge clk);
      a = (a & ~63) | ((a + 1) & 63);
    end
    arrayWrReq = 1'b0;
    #1;
    chk("R7 walk final addr", int'(arrAddr), a);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state, even with a load pending
    loadAddr = 1'b1; byteAddr = 13'h0ABC;
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", int'(arrAddr), 0);
    loadAddr = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 addr after reset", int'(arrAddr), 0);

    // R2, R5: all select pairs under every protection encoding
    for (int f = 0; f < 8; f++) begin
      for (int s = 0; s < 4; s++) begin
        for (int b = 0; b < 4; b++) begin
          protField = 3'(f); selPins = 2'(s); busSel = 2'(b); ctrlWrReq = 1'b1;
          #1;
          chk("R2 addrMatch", int'(addrMatch), (s == b) ? 1 : 0);
          chk("R5 ctrlWrEn vs field", int'(ctrlWrEn), (s == b) ? 1 : 0);
        end
      end
    end
    ctrlWrReq = 1'b0; selPins = 2'b10; busSel = 2'b10; protField = 3'b000;

    // R9: write-protect pin and enable bit
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      wpPin = w[0]; wpEnBit = w[1]; ctrlWrReq = 1'b1;
      #1;
      chk("R9 ctrlWrEn", int'(ctrlWrEn), (w == 3) ? 0 : 1);
    end
    wpPin = 1'b0; wpEnBit = 1'b0; ctrlWrReq = 1'b0;

    // R3: unmatched requests have no effect
    loadTo(13'h0100);
    @(negedge clk);
    busSel = 2'b01; loadAddr = 1'b1; byteAddr = 13'd5;
    arrayWrReq = 1'b1; ctrlWrReq = 1'b1;
    #1;
    chk("R3 array blocked", int'(arrayWrEn), 0);
    chk("R3 ctrl blocked", int'(ctrlWrEn), 0);
    @(negedge clk);
    chk("R3 addr held after load", int'(arrAddr), 13'h0100);
    loadAddr = 1'b0;
    @(negedge clk);
    chk("R3 addr held after write", int'(arrAddr), 13'h0100);
    busSel = 2'b10; arrayWrReq = 1'b0; ctrlWrReq = 1'b0;

    // R6: load wins over step
    @(negedge clk);
    loadAddr = 1'b1; arrayWrReq = 1'b1; byteAddr = 13'h0ABC;
    @(negedge clk);
    loadAddr = 1'b0; arrayWrReq = 1'b0;
    chk("R6 load priority", int'(arrAddr), 13'h0ABC);

    // R4, R8: every encoding against every address, one address per cycle
    for (int f = 0; f < 8; f++) begin
      @(negedge clk);
      protField = 3'(f); loadAddr = 1'b1; arrayWrReq = 1'b0; byteAddr = '0;
      for (int a = 0; a < 8192; a++) begin
        @(negedge clk);
        byteAddr = AW'(a + 1); loadAddr = 1'b1; arrayWrReq = 1'b1;
        #1;
        chk("R6 sweep addr", int'(arrAddr), a);
        chk("R4 sweep enable", int'(arrayWrEn), (a >= protLo(f)) ? 0 : 1);
        chk("R8 sweep pageEnd", int'(pageEnd), ((a % 64) == 63) ? 1 : 0);
      end
      loadAddr = 1'b0; arrayWrReq = 1'b0;
    end

    // R7: page walks with wrap, protected and unprotected pages
    walk(5, 13'h1F7E, 4);
    walk(6, 13'h1F3E, 4);
    walk(4, 13'h1FFE, 3);
    walk(0, 13'h0000, 66);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule